// File: doc/BRIEF.md
# Memory-mapped power-management bus command port

This block is a 32-bit register-mapped slave through which software issues one power-management bus transaction at a time. Software fills a set of command registers (slave ID, byte count, target address high and low bytes) and up to eight write-data byte registers. It then writes the opcode register, and that write is what launches the transaction. The block latches the whole command and presents it to a back-end bus engine over a valid/ready request channel. It then waits for a single-cycle response that carries failure and denied indications and up to eight read-data bytes.

Software polls a four-bit status register and, once done is reported, collects the read-data bytes. A start that arrives while a transaction is still in flight is not forwarded. A start carrying an opcode outside the supported set, or a byte count above the maximum, completes at once without touching the bus. A fuse-driven disable input blocks every launch. The register bus is a single-cycle write strobe with combinational read data that follows the address.

Top module: `pmic_cmd_port`

## Requirements
- R1: After reset every mapped register reads zero, the status register reads zero and no request is presented to the back end.
- R2: Register map (word offsets): opcode at 0x00, reading back opcode<<1; count/slave at 0x04, with byte count minus one in bits [7:4] and slave ID in bits [3:0]; target address high byte at 0x08; target address low byte at 0x0C; status at 0x14; write-data byte n at 0x18+4n; read-data byte n at 0x38+4n, read-only. The data registers keep bits [7:0] of a write. Any other address, including unaligned ones, reads zero and ignores writes.
- R3: A write to 0x00 with the fuse input low, the port idle, a supported opcode and a count field of at most 7 clears status to 0. From the next cycle the block presents one request whose fields are: opcode = written bits [5:1], with bit 0 and bits above 5 ignored; slave ID; count minus one; address {high byte, low byte}; and write-data byte n in bits [8n+7:8n].
- R4: While the request is valid and not accepted, valid stays high and every request field stays unchanged.
- R5: On the response the status becomes done (bit 0) with failure (bit 1) and denied (bit 2) taken from the response. All eight read-data bytes are captured, and byte n of the response (bits [8n+7:8n]) becomes readable at 0x38+4n.
- R6: A start written while a transaction is pending (requested or awaiting response) is not forwarded and sets status to 0x9 (done and dropped). The pending transaction still completes and then overwrites the status with its own result.
- R7: The supported opcodes are 0 to 9 and 13 to 16. A start with any other opcode sets status to 0x5 (done and denied) on the next cycle and issues no request.
- R8: A start whose count field (bits [7:4] of 0x04) exceeds 7 sets status to 0x5 and issues no request.
- R9: While the fuse-disable input is high, start writes issue no request and leave the status unchanged.
- R10: Failure, denied and dropped are never reported without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fuse_disable | input | 1 | High blocks all transaction launches |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| be_req_valid | output | 1 | Request to back end valid |
| be_req_ready | input | 1 | Back end accepts request |
| be_req_opcode | output | 5 | Latched opcode |
| be_req_sid | output | 4 | Latched slave ID |
| be_req_addr | output | 16 | Latched target address |
| be_req_len_m1 | output | 3 | Latched byte count minus one |
| be_req_wdata | output | 64 | Latched write-data bytes, byte n at [8n+7:8n] |
| be_rsp_valid | input | 1 | Single-cycle response strobe |
| be_rsp_fail | input | 1 | Response failure indication |
| be_rsp_denied | input | 1 | Response denied indication |
| be_rsp_rdata | input | 64 | Response read-data bytes |

## Verification
Full-width write transactions with a slow accept show that the request fields are packed correctly and held stable, while short read transactions with varied response flags show that failure, denied and read-data capture are reported separately. Starts with unsupported opcodes and oversized counts are separated from accepted ones by the absence of any request and by a 0x5 status. A second start during the wait phase and a start with the fuse input high are each told apart by their status: 0x9 in the first case, the status left unchanged in the second. A cycle-level reference model checks every cycle that a request is issued exactly when one is due.

// File: rtl/pmic_cmd_pkg.sv
package pmic_cmd_pkg;

  localparam int OFF_OPC    = 'h00;
  localparam int OFF_CNTSID = 'h04;
  localparam int OFF_ADRHI  = 'h08;
  localparam int OFF_ADRLO  = 'h0C;
  localparam int OFF_STAT   = 'h14;
  localparam int OFF_WBASE  = 'h18;
  localparam int OFF_RBASE  = 'h38;

  localparam int OPC_W = 5;
  localparam int SID_W = 4;
  localparam int CNT_W = 4;

  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_FAIL = 1;
  localparam int ST_DENY = 2;
  localparam int ST_DROP = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_XLONG_WR = 5'd0,
    OP_XLONG_RD = 5'd1,
    OP_EXT_WR   = 5'd2,
    OP_RESET    = 5'd3,
    OP_SLEEP    = 5'd4,
    OP_SHUTDOWN = 5'd5,
    OP_WAKEUP   = 5'd6,
    OP_AUTH     = 5'd7,
    OP_MST_RD   = 5'd8,
    OP_MST_WR   = 5'd9,
    OP_EXT_RD   = 5'd13,
    OP_REG_WR   = 5'd14,
    OP_REG_RD   = 5'd15,
    OP_ZERO_WR  = 5'd16
  } bus_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  function automatic logic opc_known(input logic [OPC_W-1:0] op);
    case (op)
      OP_XLONG_WR, OP_XLONG_RD, OP_EXT_WR, OP_RESET, OP_SLEEP,
      OP_SHUTDOWN, OP_WAKEUP, OP_AUTH, OP_MST_RD, OP_MST_WR,
      OP_EXT_RD, OP_REG_WR, OP_REG_RD, OP_ZERO_WR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmic_cmd_regs.sv
module pmic_cmd_regs
  import pmic_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [3:0]               status,
  input  logic                     rsp_capture,
  input  logic [8*MAX_BYTES-1:0]   rsp_rdata,
  output logic                     start,
  output logic [OPC_W-1:0]         start_opc,
  output logic [SID_W-1:0]         cfg_sid,
  output logic [CNT_W-1:0]         cfg_cnt,
  output logic [15:0]              cfg_addr,
  output logic [8*MAX_BYTES-1:0]   cfg_wbytes
);

  localparam logic [ADDR_W-1:0] A_OPC    = ADDR_W'(OFF_OPC);
  localparam logic [ADDR_W-1:0] A_CNTSID = ADDR_W'(OFF_CNTSID);
  localparam logic [ADDR_W-1:0] A_ADRHI  = ADDR_W'(OFF_ADRHI);
  localparam logic [ADDR_W-1:0] A_ADRLO  = ADDR_W'(OFF_ADRLO);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);

  logic [OPC_W-1:0] opc_q;
  logic [SID_W-1:0] sid_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       hi_q, lo_q;
  logic [7:0]       wb_q [MAX_BYTES];
  logic [7:0]       rb_q [MAX_BYTES];
  logic [MAX_BYTES-1:0] wb_hit;

  logic hit_opc, hit_cs, hit_hi, hit_lo;

  assign hit_opc = reg_wr_en && (reg_addr == A_OPC);
  assign hit_cs  = reg_wr_en && (reg_addr == A_CNTSID);
  assign hit_hi  = reg_wr_en && (reg_addr == A_ADRHI);
  assign hit_lo  = reg_wr_en && (reg_addr == A_ADRLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= '0;
    end else if (hit_opc) begin
      opc_q <= reg_wdata[OPC_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sid_q <= '0;
      cnt_q <= '0;
    end else if (hit_cs) begin
      sid_q <= reg_wdata[SID_W-1:0];
      cnt_q <= reg_wdata[SID_W+CNT_W-1:SID_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hit_hi) begin
      hi_q <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (hit_lo) begin
      lo_q <= reg_wdata[7:0];
    end
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] A_WB = ADDR_W'(OFF_WBASE + 4*i);

    assign wb_hit[i] = reg_wr_en && (reg_addr == A_WB);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wb_q[i] <= '0;
      end else if (wb_hit[i]) begin
        wb_q[i] <= reg_wdata[7:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rb_q[i] <= '0;
      end else if (rsp_capture) begin
        rb_q[i] <= rsp_rdata[8*i +: 8];
      end
    end

    assign cfg_wbytes[8*i +: 8] = wb_q[i];
  end

  assign start     = hit_opc;
  assign start_opc = reg_wdata[OPC_W:1];
  assign cfg_sid   = sid_q;
  assign cfg_cnt   = cnt_q;
  assign cfg_addr  = {hi_q, lo_q};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_OPC:    reg_rdata = DATA_W'({opc_q, 1'b0});
      A_CNTSID: reg_rdata = DATA_W'({cnt_q, sid_q});
      A_ADRHI:  reg_rdata = DATA_W'(hi_q);
      A_ADRLO:  reg_rdata = DATA_W'(lo_q);
      A_STAT:   reg_rdata = DATA_W'(status);
      default:  reg_rdata = '0;
    endcase
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (reg_addr == ADDR_W'(OFF_WBASE + 4*i)) reg_rdata = DATA_W'(wb_q[i]);
      if (reg_addr == ADDR_W'(OFF_RBASE + 4*i)) reg_rdata = DATA_W'(rb_q[i]);
    end
  end

endmodule

// File: rtl/pmic_cmd_ctrl.sv
module pmic_cmd_ctrl
  import pmic_cmd_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fuse_disable,
  input  logic                          start,
  input  logic [OPC_W-1:0]              start_opc,
  input  logic [SID_W-1:0]              cfg_sid,
  input  logic [CNT_W-1:0]              cfg_cnt,
  input  logic [15:0]                   cfg_addr,
  input  logic [8*MAX_BYTES-1:0]        cfg_wbytes,
  output logic [3:0]                    status,
  output logic                          rsp_capture,
  output logic                          be_req_valid,
  input  logic                          be_req_ready,
  output logic [OPC_W-1:0]              be_req_opcode,
  output logic [SID_W-1:0]              be_req_sid,
  output logic [15:0]                   be_req_addr,
  output logic [$clog2(MAX_BYTES)-1:0]  be_req_len_m1,
  output logic [8*MAX_BYTES-1:0]        be_req_wdata,
  input  logic                          be_rsp_valid,
  input  logic                          be_rsp_fail,
  input  logic                          be_rsp_denied
);

  localparam int LEN_W = $clog2(MAX_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES - 1);

  phase_e     ph_q, ph_d;
  logic [3:0] st_q, st_d;
  logic       latch_en;
  logic       go, busy, cmd_ok;

  logic [OPC_W-1:0]       l_opc;
  logic [SID_W-1:0]       l_sid;
  logic [15:0]            l_addr;
  logic [LEN_W-1:0]       l_len;
  logic [8*MAX_BYTES-1:0] l_wdata;

  assign go          = start && !fuse_disable;
  assign busy        = (ph_q != PH_IDLE);
  assign cmd_ok      = opc_known(start_opc) && (cfg_cnt <= CNT_MAX);
  assign rsp_capture = (ph_q == PH_WAIT) && be_rsp_valid;

  always_comb begin
    ph_d     = ph_q;
    st_d     = st_q;
    latch_en = 1'b0;
    case (ph_q)
      PH_REQ:  if (be_req_ready) ph_d = PH_WAIT;
      PH_WAIT: if (be_rsp_valid) begin
                 ph_d = PH_IDLE;
                 st_d = '0;
                 st_d[ST_DONE] = 1'b1;
                 st_d[ST_FAIL] = be_rsp_fail;
                 st_d[ST_DENY] = be_rsp_denied;
               end
      default: ph_d = ph_q;
    endcase
    if (go) begin
      if (busy) begin
        st_d = '0;
        st_d[ST_DONE] = 1'b1;
        st_d[ST_DROP] = 1'b1;
      end else if (!cmd_ok) begin
        st_d = '0;
        st_d[ST_DONE] = 1'b1;
        st_d[ST_DENY] = 1'b1;
      end else begin
        st_d     = '0;
        ph_d     = PH_REQ;
        latch_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      st_q <= '0;
    end else begin
      ph_q <= ph_d;
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_opc   <= '0;
      l_sid   <= '0;
      l_addr  <= '0;
      l_len   <= '0;
      l_wdata <= '0;
    end else if (latch_en) begin
      l_opc   <= start_opc;
      l_sid   <= cfg_sid;
      l_addr  <= cfg_addr;
      l_len   <= cfg_cnt[LEN_W-1:0];
      l_wdata <= cfg_wbytes;
    end
  end

  assign status        = st_q;
  assign be_req_valid  = (ph_q == PH_REQ);
  assign be_req_opcode = l_opc;
  assign be_req_sid    = l_sid;
  assign be_req_addr   = l_addr;
  assign be_req_len_m1 = l_len;
  assign be_req_wdata  = l_wdata;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid && !be_req_ready |=> be_req_valid &&
      $stable({be_req_opcode, be_req_sid, be_req_addr, be_req_len_m1, be_req_wdata})); // R4

  AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_req_valid) |-> (status == 4'b0000)); // R3

  AST_RSP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAIT) && be_rsp_valid && !go |=>
      status[ST_DONE] && (status[ST_FAIL] == $past(be_rsp_fail)) &&
      (status[ST_DENY] == $past(be_rsp_denied))); // R5

  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go && busy |=> (status == 4'b1001)); // R6

  AST_BAD_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    go && !busy && !opc_known(start_opc) |=> (status == 4'b0101) && !be_req_valid); // R7

  AST_BIG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    go && !busy && (cfg_cnt > CNT_MAX) |=> (status == 4'b0101) && !be_req_valid); // R8

  AST_FUSE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    start && fuse_disable && !busy |=> !be_req_valid && $stable(status)); // R9

  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|status[3:1]) |-> status[ST_DONE]); // R10

endmodule

// File: rtl/pmic_cmd_port.sv
module pmic_cmd_port
  import pmic_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fuse_disable,
  input  logic                          reg_wr_en,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic                          be_req_valid,
  input  logic                          be_req_ready,
  output logic [OPC_W-1:0]              be_req_opcode,
  output logic [SID_W-1:0]              be_req_sid,
  output logic [15:0]                   be_req_addr,
  output logic [$clog2(MAX_BYTES)-1:0]  be_req_len_m1,
  output logic [8*MAX_BYTES-1:0]        be_req_wdata,
  input  logic                          be_rsp_valid,
  input  logic                          be_rsp_fail,
  input  logic                          be_rsp_denied,
  input  logic [8*MAX_BYTES-1:0]        be_rsp_rdata
);

  logic rst_meta_n, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  logic                   start;
  logic [OPC_W-1:0]       start_opc;
  logic [SID_W-1:0]       cfg_sid;
  logic [CNT_W-1:0]       cfg_cnt;
  logic [15:0]            cfg_addr;
  logic [8*MAX_BYTES-1:0] cfg_wbytes;
  logic [3:0]             status;
  logic                   rsp_capture;

  pmic_cmd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status(status),
    .rsp_capture(rsp_capture), .rsp_rdata(be_rsp_rdata),
    .start(start), .start_opc(start_opc), .cfg_sid(cfg_sid),
    .cfg_cnt(cfg_cnt), .cfg_addr(cfg_addr), .cfg_wbytes(cfg_wbytes)
  );

  pmic_cmd_ctrl #(
    .MAX_BYTES(MAX_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .fuse_disable(fuse_disable),
    .start(start), .start_opc(start_opc), .cfg_sid(cfg_sid),
    .cfg_cnt(cfg_cnt), .cfg_addr(cfg_addr), .cfg_wbytes(cfg_wbytes),
    .status(status), .rsp_capture(rsp_capture),
    .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
    .be_req_opcode(be_req_opcode), .be_req_sid(be_req_sid),
    .be_req_addr(be_req_addr), .be_req_len_m1(be_req_len_m1),
    .be_req_wdata(be_req_wdata),
    .be_rsp_valid(be_rsp_valid), .be_rsp_fail(be_rsp_fail),
    .be_rsp_denied(be_rsp_denied)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> !be_req_valid && (status == 4'b0000)); // R1

endmodule

// File: tb/sim_pmic_cmd_port.sv
module sim_pmic_cmd_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fuse_disable = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        be_req_valid;
  logic        be_req_ready = 1'b0;
  logic [4:0]  be_req_opcode;
  logic [3:0]  be_req_sid;
  logic [15:0] be_req_addr;
  logic [2:0]  be_req_len_m1;
  logic [63:0] be_req_wdata;
  logic        be_rsp_valid = 1'b0;
  logic        be_rsp_fail = 1'b0;
  logic        be_rsp_denied = 1'b0;
  logic [63:0] be_rsp_rdata = '0;

  always #5 clk = ~clk;

  pmic_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .fuse_disable(fuse_disable),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
    .be_req_opcode(be_req_opcode), .be_req_sid(be_req_sid),
    .be_req_addr(be_req_addr), .be_req_len_m1(be_req_len_m1),
    .be_req_wdata(be_req_wdata),
    .be_rsp_valid(be_rsp_valid), .be_rsp_fail(be_rsp_fail),
    .be_rsp_denied(be_rsp_denied), .be_rsp_rdata(be_rsp_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  // ---------------- reference model ----------------
  int        m_state = 0;          // 0 idle, 1 requesting, 2 waiting
  bit [3:0]  m_status = 0;
  bit [4:0]  m_opc = 0;
  bit [3:0]  m_sid = 0, m_cnt = 0;
  bit [7:0]  m_hi = 0, m_lo = 0;
  bit [7:0]  m_wb [8];
  bit [7:0]  m_rb [8];
  bit [4:0]  q_opc;
  bit [3:0]  q_sid;
  bit [15:0] q_addr;
  bit [2:0]  q_len;
  bit [63:0] q_wdata;
  int        issue_cnt = 0;

  function automatic bit supported(bit [4:0] op);
    return (op <= 9) || (op >= 13 && op <= 16);
  endfunction

  always @(posedge clk) begin
    int s0;
    s0 = m_state;
    if (rst_n) begin
      if (s0 == 1 && be_req_ready) m_state = 2;
      if (s0 == 2 && be_rsp_valid) begin
        m_status = {1'b0, be_rsp_denied, be_rsp_fail, 1'b1};
        for (int i = 0; i < 8; i++) m_rb[i] = be_rsp_rdata[8*i +: 8];
        m_state = 0;
      end
      if (reg_wr_en) begin
        case (reg_addr)
          8'h00: begin
            m_opc = reg_wdata[5:1];
            if (!fuse_disable) begin
              if (s0 != 0) m_status = 4'h9;
              else if (!supported(reg_wdata[5:1]) || m_cnt > 7) m_status = 4'h5;
              else begin
                m_status = 0;
                m_state  = 1;
                q_opc    = reg_wdata[5:1];
                q_sid    = m_sid;
                q_addr   = {m_hi, m_lo};
                q_len    = m_cnt[2:0];
                for (int i = 0; i < 8; i++) q_wdata[8*i +: 8] = m_wb[i];
                issue_cnt++;
              end
            end
          end
          8'h04: begin m_sid = reg_wdata[3:0]; m_cnt = reg_wdata[7:4]; end
          8'h08: m_hi = reg_wdata[7:0];
          8'h0C: m_lo = reg_wdata[7:0];
          default: begin
            for (int i = 0; i < 8; i++)
              if (reg_addr == 8'(8'h18 + 4*i)) m_wb[i] = reg_wdata[7:0];
          end
        endcase
      end
    end
  end

  function automatic bit [31:0] m_read(bit [7:0] a);
    bit [31:0] r;
    r = 0;
    case (a)
      8'h00: r = {26'b0, m_opc, 1'b0};
      8'h04: r = {24'b0, m_cnt, m_sid};
      8'h08: r = {24'b0, m_hi};
      8'h0C: r = {24'b0, m_lo};
      8'h14: r = {28'b0, m_status};
      default: for (int i = 0; i < 8; i++) begin
        if (a == 8'(8'h18 + 4*i)) r = {24'b0, m_wb[i]};
        if (a == 8'(8'h38 + 4*i)) r = {24'b0, m_rb[i]};
      end
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of the request channel
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check("R3/R9 request valid", be_req_valid, m_state == 1);
      if (be_req_valid && m_state == 1) begin
        check("R3 opcode", be_req_opcode, q_opc);
        check("R3 sid", be_req_sid, q_sid);
        check("R3 addr", be_req_addr, q_addr);
        check("R3 len", be_req_len_m1, q_len);
        check("R4 wdata", be_req_wdata, q_wdata);
      end
    end
  end

  // ---------------- back-end stub ----------------
  int  ready_delay = 0, rsp_delay = 2;
  bit  cfg_fail = 0, cfg_den = 0;
  int  sb_state = 0, sb_cnt = 0;

  always @(negedge clk) begin
    case (sb_state)
      0: if (be_req_valid) begin sb_cnt = ready_delay; sb_state = 1; end
      1: if (sb_cnt == 0) begin be_req_ready <= 1'b1; sb_state = 2; end
         else sb_cnt--;
      2: begin
        be_req_ready <= 1'b0;
        be_rsp_rdata <= 64'h0123_4567_89AB_CDEF ^ {4{be_req_addr}};
        sb_cnt = rsp_delay;
        sb_state = 3;
      end
      3: if (sb_cnt == 0) begin
           be_rsp_valid  <= 1'b1;
           be_rsp_fail   <= cfg_fail;
           be_rsp_denied <= cfg_den;
           sb_state = 4;
         end else sb_cnt--;
      default: begin
        be_rsp_valid  <= 1'b0;
        be_rsp_fail   <= 1'b0;
        be_rsp_denied <= 1'b0;
        sb_state = 0;
      end
    endcase
  end

  // ---------------- tasks ----------------
  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input bit [7:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, m_read(a));
    if (a == 8'h14 && (|reg_rdata[3:1])) check("R10 error without done", reg_rdata[0], 1'b1);
  endtask

  task automatic stat_is(input string tag, input bit [3:0] exp);
    @(negedge clk);
    reg_addr = 8'h14;
    #1;
    check(tag, reg_rdata, {28'b0, exp});
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && (m_state != 0 || sb_state != 0); k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_wb[i] = 0; m_rb[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    foreach (m_wb[i]) ;
    rd_chk("R1 opc reset", 8'h00);
    rd_chk("R1 cntsid reset", 8'h04);
    rd_chk("R1 hi reset", 8'h08);
    rd_chk("R1 lo reset", 8'h0C);
    stat_is("R1 status reset", 4'h0);
    rd_chk("R1 wbyte reset", 8'h18);
    rd_chk("R1 rbyte reset", 8'h38);

    // R2 register map
    wr(8'h04, 32'hFFFF_FF73);
    wr(8'h08, 32'h1234_56AB);
    wr(8'h0C, 32'h0000_01CD);
    for (int i = 0; i < 8; i++) wr(8'(8'h18 + 4*i), 32'hA500 + 32'(i*17));
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h19, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    rd_chk("R2 cntsid", 8'h04);
    @(negedge clk); reg_addr = 8'h04; #1; check("R2 cntsid literal", reg_rdata, 32'h73);
    rd_chk("R2 hi", 8'h08);
    rd_chk("R2 lo", 8'h0C);
    for (int i = 0; i < 8; i++) rd_chk("R2 wbyte", 8'(8'h18 + 4*i));
    rd_chk("R2 unmapped 0x10", 8'h10);
    rd_chk("R2 unaligned 0x19", 8'h19);
    rd_chk("R2 rbyte read-only", 8'h38);
    rd_chk("R2 unmapped 0x58", 8'h58);

    // R3/R4/R5 full write transaction, slow accept; bit0 and high bits ignored
    ready_delay = 3; rsp_delay = 2; cfg_fail = 0; cfg_den = 0;
    wr(8'h00, 32'hFFFF_FFDD);
    stat_is("R3 status cleared", 4'h0);
    wait_idle();
    stat_is("R5 done", 4'h1);
    rd_chk("R2 opc readback", 8'h00);
    for (int i = 0; i < 8; i++) rd_chk("R5 read byte", 8'(8'h38 + 4*i));

    // R5 read with failure, short count
    wr(8'h04, 32'h0000_0025);
    wr(8'h08, 32'h0000_0040);
    ready_delay = 0; rsp_delay = 4; cfg_fail = 1;
    wr(8'h00, {26'b0, 5'd15, 1'b0});
    wait_idle();
    stat_is("R5 fail flag", 4'h3);
    @(negedge clk); reg_addr = 8'h3C; #1;
    check("R5 read byte1 literal", reg_rdata, {24'b0, 8'hCD ^ 8'h40});
    for (int i = 0; i < 8; i++) rd_chk("R5 read byte", 8'(8'h38 + 4*i));

    // R5 denied
    cfg_fail = 0; cfg_den = 1;
    wr(8'h00, {26'b0, 5'd13, 1'b0});
    wait_idle();
    stat_is("R5 denied flag", 4'h5);
    cfg_den = 0;

    // R6 drop while pending
    rsp_delay = 8;
    wr(8'h00, {26'b0, 5'd1, 1'b0});
    repeat (3) @(negedge clk);
    wr(8'h00, {26'b0, 5'd14, 1'b0});
    stat_is("R6 dropped", 4'h9);
    wait_idle();
    stat_is("R6 original completes", 4'h1);
    check("R6 single request", issue_cnt, 4);
    rsp_delay = 2;

    // R7 unsupported opcodes
    for (int k = 0; k < 5; k++) begin
      bit [4:0] bad;
      bad = (k == 0) ? 5'd10 : (k == 1) ? 5'd11 : (k == 2) ? 5'd12 : (k == 3) ? 5'd17 : 5'd31;
      wr(8'h00, {26'b0, bad, 1'b0});
      stat_is("R7 unsupported opcode", 4'h5);
    end
    wr(8'h00, {26'b0, 5'd16, 1'b0});
    wait_idle();
    stat_is("R7 opcode 16 accepted", 4'h1);

    // R8 oversized count
    wr(8'h04, 32'h0000_0082);
    wr(8'h00, {26'b0, 5'd14, 1'b0});
    stat_is("R8 count 9 rejected", 4'h5);
    wr(8'h04, 32'h0000_00F2);
    wr(8'h00, {26'b0, 5'd0, 1'b0});
    stat_is("R8 count 16 rejected", 4'h5);
    check("R8 no request", issue_cnt, 5);

    // R9 fuse disable
    wr(8'h04, 32'h0000_0011);
    @(negedge clk); fuse_disable = 1'b1;
    wr(8'h00, {26'b0, 5'd14, 1'b0});
    repeat (6) @(negedge clk);
    stat_is("R9 status unchanged", 4'h5);
    check("R9 no request", issue_cnt, 5);
    @(negedge clk); fuse_disable = 1'b0;
    wr(8'h00, {26'b0, 5'd14, 1'b0});
    wait_idle();
    stat_is("R9 usable after fuse low", 4'h1);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule